// File: doc/BRIEF.md
# Display Line Timer with Status Register

This block paces a display raster. It runs a dot counter that splits every line into a drawing part and a horizontal blanking tail. It also runs a line counter that advances each time a new drawing part begins. From these two counters it derives three live flags: inside horizontal blank, inside vertical blank, and line equals the programmed compare value. It also produces single-cycle pulses for interrupts, DMA triggers and frame starts, which other blocks consume.

Software reads one status word. The three flags sit in its lowest bits. Above them are three interrupt enables, two spare writable bits and an 8-bit line compare value. A write updates only the upper part of the word, so software cannot disturb the flags. Every clock cycle is one dot. Line length, blanking length, visible line count and total line count are all parameters.

Top module: `disp_line_timer`

## Requirements
- R1: `line` is 0 after reset. It advances by one on the cycle in which `in_hblank` falls, which is the start of a drawing part. After line TOTAL_LINES-1 it returns to 0. At no other time does it change.
- R2: `line_match` (status bit 2) is updated only when a drawing part starts. It becomes 1 if the new line equals the compare value held in status bits 15:8, and 0 otherwise. Line values above 255 never match. A compare value written in the middle of a line has no effect on the flag until the next drawing part starts.
- R3: `irq_match` pulses for one cycle as a drawing part starts, if the new line matches the compare value and status bit 5 was set before that edge.
- R4: `in_vblank` (status bit 0) becomes 1 when the line counter reaches VIS_LINES, and becomes 0 when it reaches TOTAL_LINES-1. When it is set, `dma_vblank` pulses for one cycle. In that same cycle `irq_vblank` pulses if status bit 3 was set.
- R5: `in_hblank` (status bit 1) is 1 for the last HBLANK_DOTS dots of each line. As it rises, `irq_hblank` pulses for one cycle if status bit 4 was set.
- R6: `dma_hblank` pulses for one cycle as horizontal blanking begins, and only on lines below VIS_LINES.
- R7: A write (`wr_en` high at a clock edge) stores `wr_data` bits 15:3 into status bits 15:3. These are readable from the next cycle. Status bits 2:0 always show the three flags, whatever the written data.
- R8: `frame_start` pulses for one cycle when the line counter wraps back to 0.
- R9: While `rst` is high at a clock edge, all flags, pulses, the line counter and status bits 15:3 are cleared. Counting resumes from dot 0 of line 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock, one dot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 16 | Status write data; bits 2:0 ignored |
| status | output | 16 | Compare value, spare bits, enables and flags |
| line | output | clog2(TOTAL_LINES) | Current line number |
| in_hblank | output | 1 | Horizontal blanking flag |
| in_vblank | output | 1 | Vertical blanking flag |
| line_match | output | 1 | Line equals compare value |
| irq_hblank | output | 1 | Horizontal blank interrupt pulse |
| irq_vblank | output | 1 | Vertical blank interrupt pulse |
| irq_match | output | 1 | Line compare interrupt pulse |
| dma_hblank | output | 1 | Horizontal blank DMA trigger pulse |
| dma_vblank | output | 1 | Vertical blank DMA trigger pulse |
| frame_start | output | 1 | Line counter wrapped to 0 |

## Verification
The properties assume that reset is synchronous and that the parameters are consistent. That means HBLANK_DOTS is smaller than LINE_DOTS, and VIS_LINES is below TOTAL_LINES-1. The properties place no restriction on when a write may arrive. A write that lands on the same edge as a drawing start is checked against the compare value and enables held before that edge. The stimulus deliberately writes during several phases: mid-line, inside vertical blank with the flags set, and right before wrap. The bench reduces the raster to a few dots and lines so that several full frames fit in a short run.

// File: rtl/lst_pkg.sv
package lst_pkg;
  localparam int FLAG_N     = 3;
  localparam int BIT_VBLANK = 0;
  localparam int BIT_HBLANK = 1;
  localparam int BIT_MATCH  = 2;
  localparam int BIT_EN_VB  = 3;
  localparam int BIT_EN_HB  = 4;
  localparam int BIT_EN_MT  = 5;
  localparam int CMP_LO     = 8;

  typedef struct packed {
    logic blank_start;
    logic draw_start;
  } lst_evt_t;
endpackage

// File: rtl/lst_dot_ctr.sv
module lst_dot_ctr
  import lst_pkg::*;
#(
  parameter int LINE_DOTS   = 355,
  parameter int HBLANK_DOTS = 99
) (
  input  logic     clk,
  input  logic     rst,
  output lst_evt_t evt,
  output logic     in_hblank
);
  localparam int DW        = $clog2(LINE_DOTS);
  localparam int DRAW_DOTS = LINE_DOTS - HBLANK_DOTS;

  logic [DW-1:0] dot_q;

  assign evt.blank_start = (dot_q == DW'(DRAW_DOTS - 1));
  assign evt.draw_start  = (dot_q == DW'(LINE_DOTS - 1));

  always_ff @(posedge clk) begin
    if (rst)                 dot_q <= '0;
    else if (evt.draw_start) dot_q <= '0;
    else                     dot_q <= dot_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                  in_hblank <= 1'b0;
    else if (evt.blank_start) in_hblank <= 1'b1;
    else if (evt.draw_start)  in_hblank <= 1'b0;
  end
endmodule

// File: rtl/lst_line_seq.sv
module lst_line_seq #(
  parameter int VIS_LINES   = 192,
  parameter int TOTAL_LINES = 263,
  parameter int CMP_W       = 8,
  localparam int LW         = $clog2(TOTAL_LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             draw_start,
  input  logic [CMP_W-1:0] cmp,
  output logic [LW-1:0]    line_q,
  output logic             in_vblank,
  output logic             line_match,
  output logic             line_vis,
  output logic             vb_hit,
  output logic             wrap_hit,
  output logic             match_hit
);
  localparam int CW = (LW > CMP_W) ? LW : CMP_W;

  logic [LW-1:0] nxt;

  assign nxt       = (line_q == LW'(TOTAL_LINES - 1)) ? '0 : line_q + 1'b1;
  assign line_vis  = (line_q < LW'(VIS_LINES));
  assign vb_hit    = draw_start && (nxt == LW'(VIS_LINES));
  assign wrap_hit  = draw_start && (nxt == '0);
  assign match_hit = draw_start && (CW'(nxt) == CW'(cmp));

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q     <= '0;
      in_vblank  <= 1'b0;
      line_match <= 1'b0;
    end else if (draw_start) begin
      line_q     <= nxt;
      line_match <= match_hit;
      if (nxt == LW'(VIS_LINES))            in_vblank <= 1'b1;
      else if (nxt == LW'(TOTAL_LINES - 1)) in_vblank <= 1'b0;
    end
  end
endmodule

// File: rtl/lst_cfg_reg.sv
module lst_cfg_reg
  import lst_pkg::*;
#(
  parameter int ST_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [ST_W-1:FLAG_N]   wr_data,
  output logic [ST_W-1:FLAG_N]   cfg_q
);
  always_ff @(posedge clk) begin
    if (rst)        cfg_q <= '0;
    else if (wr_en) cfg_q <= wr_data;
  end
endmodule

// File: rtl/disp_line_timer.sv
module disp_line_timer
  import lst_pkg::*;
#(
  parameter int LINE_DOTS   = 355,
  parameter int HBLANK_DOTS = 99,
  parameter int VIS_LINES   = 192,
  parameter int TOTAL_LINES = 263,
  parameter int CMP_W       = 8,
  localparam int LW         = $clog2(TOTAL_LINES),
  localparam int ST_W       = CMP_LO + CMP_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [ST_W-1:0] wr_data,
  output logic [ST_W-1:0] status,
  output logic [LW-1:0]   line,
  output logic            in_hblank,
  output logic            in_vblank,
  output logic            line_match,
  output logic            irq_hblank,
  output logic            irq_vblank,
  output logic            irq_match,
  output logic            dma_hblank,
  output logic            dma_vblank,
  output logic            frame_start
);
  lst_evt_t                evt;
  logic [ST_W-1:FLAG_N]    cfg_q;
  logic                    line_vis, vb_hit, wrap_hit, match_hit;
  logic                    wr_low_unused;

  assign wr_low_unused = ^wr_data[FLAG_N-1:0];

  lst_dot_ctr #(.LINE_DOTS(LINE_DOTS), .HBLANK_DOTS(HBLANK_DOTS)) u_dot (
    .clk(clk), .rst(rst), .evt(evt), .in_hblank(in_hblank)
  );

  lst_line_seq #(.VIS_LINES(VIS_LINES), .TOTAL_LINES(TOTAL_LINES), .CMP_W(CMP_W)) u_line (
    .clk(clk), .rst(rst), .draw_start(evt.draw_start),
    .cmp(cfg_q[ST_W-1:CMP_LO]),
    .line_q(line), .in_vblank(in_vblank), .line_match(line_match),
    .line_vis(line_vis), .vb_hit(vb_hit), .wrap_hit(wrap_hit), .match_hit(match_hit)
  );

  lst_cfg_reg #(.ST_W(ST_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en),
    .wr_data(wr_data[ST_W-1:FLAG_N]), .cfg_q(cfg_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_hblank  <= 1'b0;
      irq_vblank  <= 1'b0;
      irq_match   <= 1'b0;
      dma_hblank  <= 1'b0;
      dma_vblank  <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      irq_hblank  <= evt.blank_start & cfg_q[BIT_EN_HB];
      dma_hblank  <= evt.blank_start & line_vis;
      irq_vblank  <= vb_hit & cfg_q[BIT_EN_VB];
      dma_vblank  <= vb_hit;
      irq_match   <= match_hit & cfg_q[BIT_EN_MT];
      frame_start <= wrap_hit;
    end
  end

  always_comb begin
    status                  = '0;
    status[ST_W-1:FLAG_N]   = cfg_q;
    status[BIT_VBLANK]      = in_vblank;
    status[BIT_HBLANK]      = in_hblank;
    status[BIT_MATCH]       = line_match;
  end
endmodule

// File: rtl/lst_chk.sv
module lst_chk #(
  parameter int VIS_LINES   = 192,
  parameter int TOTAL_LINES = 263,
  parameter int CMP_W       = 8,
  localparam int LW         = $clog2(TOTAL_LINES),
  localparam int ST_W       = 8 + CMP_W
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic [ST_W-1:3] wr_hi,
  input logic [ST_W-1:0] status,
  input logic [LW-1:0]   line,
  input logic            in_hblank,
  input logic            in_vblank,
  input logic            line_match,
  input logic            irq_hblank,
  input logic            irq_vblank,
  input logic            irq_match,
  input logic            dma_hblank,
  input logic            dma_vblank,
  input logic            frame_start
);
  p_line_range_r1: assert property (@(posedge clk) disable iff (rst)
    int'(line) < TOTAL_LINES);

  p_line_step_r1: assert property (@(posedge clk) disable iff (rst)
    !$stable(line) |-> $fell(in_hblank) &&
      (int'(line) == ((int'($past(line)) == TOTAL_LINES - 1) ? 0 : int'($past(line)) + 1)));

  p_match_eval_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(in_hblank) |-> (line_match == (int'(line) == int'($past(status[ST_W-1:ST_W-CMP_W])))));

  p_match_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !$fell(in_hblank) |-> $stable(line_match));

  p_irq_match_r3: assert property (@(posedge clk) disable iff (rst)
    irq_match |-> line_match && $past(status[5]) && $fell(in_hblank));

  p_vb_start_r4: assert property (@(posedge clk) disable iff (rst)
    dma_vblank |-> in_vblank && int'(line) == VIS_LINES);

  p_vb_irq_r4: assert property (@(posedge clk) disable iff (rst)
    irq_vblank |-> dma_vblank && $past(status[3]));

  p_hb_irq_r5: assert property (@(posedge clk) disable iff (rst)
    irq_hblank |-> $rose(in_hblank) && $past(status[4]));

  p_hb_dma_r6: assert property (@(posedge clk) disable iff (rst)
    dma_hblank |-> $rose(in_hblank) && int'(line) < VIS_LINES);

  p_wr_keep_r7: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en) && !$past(rst) |-> status[ST_W-1:3] == $past(wr_hi));

  p_frame_r8: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> line == '0 && $fell(in_hblank));
endmodule

bind disp_line_timer lst_chk #(
  .VIS_LINES(VIS_LINES), .TOTAL_LINES(TOTAL_LINES), .CMP_W(CMP_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_hi(wr_data[ST_W-1:3]),
  .status(status), .line(line), .in_hblank(in_hblank), .in_vblank(in_vblank),
  .line_match(line_match), .irq_hblank(irq_hblank), .irq_vblank(irq_vblank),
  .irq_match(irq_match), .dma_hblank(dma_hblank), .dma_vblank(dma_vblank),
  .frame_start(frame_start)
);

// File: tb/sim_disp_line_timer.sv
`timescale 1ns/1ps
module sim_disp_line_timer;
  localparam int LD  = 10;
  localparam int HB  = 3;
  localparam int VIS = 6;
  localparam int TOT = 9;
  localparam int LW  = $clog2(TOT);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] status;
  logic [LW-1:0] line;
  logic in_hblank, in_vblank, line_match;
  logic irq_hblank, irq_vblank, irq_match, dma_hblank, dma_vblank, frame_start;

  int checks = 0;
  int errors = 0;
  int k = 0;
  logic [15:0] cfg_m = '0;
  bit m_match = 0;
  bit done = 0;

  always #10 clk = ~clk;

  disp_line_timer #(.LINE_DOTS(LD), .HBLANK_DOTS(HB), .VIS_LINES(VIS),
                    .TOTAL_LINES(TOT), .CMP_W(8)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .status(status),
    .line(line), .in_hblank(in_hblank), .in_vblank(in_vblank), .line_match(line_match),
    .irq_hblank(irq_hblank), .irq_vblank(irq_vblank), .irq_match(irq_match),
    .dma_hblank(dma_hblank), .dma_vblank(dma_vblank), .frame_start(frame_start)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, k);
    end
  endtask

  // One clock edge plus comparison of every output against the model.
  task automatic tick(input bit do_wr, input logic [15:0] d);
    int dot, ln;
    bit draw, e_hb, e_vb, e_ihb, e_dhb, e_ivb, e_dvb, e_fs, e_im;
    logic [15:0] cfg_old;
    wr_en = do_wr;
    wr_data = d;
    @(posedge clk);
    k++;
    cfg_old = cfg_m;
    dot  = k % LD;
    ln   = (k / LD) % TOT;
    draw = (dot == 0) && (k >= LD);
    if (draw) m_match = (ln == int'(cfg_old[15:8]));
    if (do_wr) cfg_m[15:3] = d[15:3];
    e_hb  = dot >= LD - HB;
    e_vb  = (ln >= VIS) && (ln < TOT - 1);
    e_ihb = (dot == LD - HB) && cfg_old[4];
    e_dhb = (dot == LD - HB) && (ln < VIS);
    e_dvb = draw && (ln == VIS);
    e_ivb = e_dvb && cfg_old[3];
    e_fs  = draw && (ln == 0);
    e_im  = draw && m_match && cfg_old[5];
    @(negedge clk);
    wr_en = 1'b0;
    chk("R1", "line", int'(line), ln);
    chk("R2", "line_match", int'(line_match), int'(m_match));
    chk("R3", "irq_match", int'(irq_match), int'(e_im));
    chk("R4", "in_vblank", int'(in_vblank), int'(e_vb));
    chk("R4", "dma_vblank", int'(dma_vblank), int'(e_dvb));
    chk("R4", "irq_vblank", int'(irq_vblank), int'(e_ivb));
    chk("R5", "in_hblank", int'(in_hblank), int'(e_hb));
    chk("R5", "irq_hblank", int'(irq_hblank), int'(e_ihb));
    chk("R6", "dma_hblank", int'(dma_hblank), int'(e_dhb));
    chk("R7", "status", int'(status),
        int'({cfg_m[15:3], m_match, e_hb, e_vb}));
    chk("R8", "frame_start", int'(frame_start), int'(e_fs));
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 16'h0000);
  endtask

  task automatic check_zero(input string what);
    chk("R9", {what, " line"}, int'(line), 0);
    chk("R9", {what, " status"}, int'(status), 0);
    chk("R9", {what, " pulses"},
        int'({irq_hblank, irq_vblank, irq_match, dma_hblank, dma_vblank, frame_start}), 0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    wr_en = 1'b1;
    wr_data = 16'hFFFF;
    repeat (3) @(negedge clk);
    wr_en = 1'b0;
    check_zero("in reset");
    rst = 1'b0;
    k = 0;
    cfg_m = '0;
    m_match = 0;
  endtask

  task automatic test_reset();
    do_reset();
    run(5);
  endtask

  task automatic test_plain_frames();   // R1 R4 R5 R6 R8 with no enables
    run(2 * LD * TOT + 5);
  endtask

  task automatic test_irq_enables();    // R2 R3 R4 R5 with compare 3
    tick(1'b1, 16'h0338);
    run(LD * TOT + 10);
  endtask

  task automatic test_cmp_edges();      // R2 R3: compare 0, last line, unreachable
    tick(1'b1, 16'h0038);
    run(LD * TOT + 5);
    tick(1'b1, 16'h0838);
    run(LD * TOT + 5);
    tick(1'b1, 16'hC838);
    run(LD * TOT + 5);
  endtask

  task automatic test_midline_cmp();    // R2: mid-line compare write waits for next line
    while ((k % LD) != 2) tick(1'b0, 16'h0000);
    tick(1'b1, {8'((k / LD) % TOT), 8'h20});
    chk("R2", "mid-line write no effect", int'(line_match), 0);
    run(3 * LD);
  endtask

  task automatic test_write_protect();  // R7: low flag bits unaffected by writes
    while (!(((k / LD) % TOT) == VIS && (k % LD) == LD - HB)) tick(1'b0, 16'h0000);
    tick(1'b1, 16'hFFFF);
    chk("R7", "flags kept after all-ones write", int'(status[2:0]), 3);
    tick(1'b1, 16'h0000);
    chk("R7", "flags kept after zero write", int'(status[1:0]), 3);
    run(2 * LD * TOT / 3);
  endtask

  task automatic test_midrun_reset();   // R9: reset in the middle of a frame
    tick(1'b1, 16'h0538);
    run(3 * LD + 4);
    do_reset();
    check_zero("after release");
    run(LD * TOT + 3);
  endtask

  initial begin
    test_reset();
    test_plain_frames();
    test_irq_enables();
    test_cmp_edges();
    test_midline_cmp();
    test_write_protect();
    test_midrun_reset();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule